// File: doc/BRIEF.md
# Receive Event Interrupt Generator

This block turns receive-path events into one level-sensitive interrupt for the host. It takes three kinds of input. The first is the end-of-frame verdict from the acceptance filter. The second is a running count of bytes buffered for the frame in progress. The third is a pair of strobes: one for a frame dropped for lack of buffer space, and one for a completed DMA transfer. Each event sets a sticky bit in a status word. The host reads that word, and the read clears it. The interrupt line is high while any status bit with its enable set is pending.

Four frame-quality events only count when the frame also passed the destination-address filter: good frame, CRC error, runt and oversize. Two early-warning events come from a small frame tracker state machine, `TRK_IDLE`, `TRK_WAIT_DA`, `TRK_WAIT_EARLY` and `TRK_DONE`:
- The destination-address event fires when the byte count first reaches 6.
- The early-data event fires when the byte count first reaches 128.

The tracker moves as follows:
- Leaving `TRK_IDLE` or `TRK_WAIT_DA`: with the frame active, it goes to `TRK_DONE` if the count is at least 128, to `TRK_WAIT_EARLY` if the count is at least 6, and to `TRK_WAIT_DA` otherwise.
- `TRK_WAIT_EARLY` advances to `TRK_DONE` when the count reaches 128.
- `TRK_DONE` holds until the frame ends.
- Any state returns to `TRK_IDLE` when the frame-active input drops.

A 10-bit missed-frame counter wraps to zero. The wrap raises its own overflow event.

Top module: `rx_event_irq`

## Requirements
- R1: Status bit 0 (good frame) sets when `frm_done` is high with `frm_da_pass`=1, `frm_crc_ok`=1, `frm_runt`=0 and `frm_long`=0.
- R2: With `frm_da_pass`=1 at `frm_done`, bit 1 sets when `frm_crc_ok`=0, bit 2 sets when `frm_runt`=1, and bit 3 sets when `frm_long`=1. Each bit follows only its own condition.
- R3: A frame that ends with `frm_da_pass`=0 changes none of bits 3:0.
- R4: Bit 4 sets in the cycle in which `byte_cnt` first reaches 6 while `frm_active` is high. It fires at most once per frame.
- R5: Bit 5 sets in the cycle in which `byte_cnt` first reaches 128 while `frm_active` is high. It fires at most once per frame and fires again in the next frame.
- R6: Bit 6 sets on `miss_stb`. Bit 8 sets on `dma_done`.
- R7: `miss_cnt` rises by one for each cycle in which `miss_stb` is high.
- R8: A `miss_stb` while `miss_cnt` is 1023 makes `miss_cnt` 0 and sets bit 7. No earlier strobe sets bit 7.
- R9: Status bits hold until a cycle with `stat_rd` high. The next cycle shows only the events that arrived during that read cycle.
- R10: `irq` is high exactly when some status bit and the matching `ev_en` bit are both 1. Disabled events still appear in `stat_q`.
- R11: After reset, `stat_q` is 0, `miss_cnt` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_active | input | 1 | High while a frame is being buffered |
| byte_cnt | input | 11 | Bytes buffered so far in the current frame |
| frm_done | input | 1 | One-cycle end-of-frame strobe qualifying the status inputs |
| frm_da_pass | input | 1 | Frame passed the destination-address filter |
| frm_crc_ok | input | 1 | Frame CRC correct |
| frm_runt | input | 1 | Frame shorter than 64 bytes |
| frm_long | input | 1 | Frame longer than 1518 bytes |
| miss_stb | input | 1 | Frame dropped, no buffer space |
| dma_done | input | 1 | One or more frames moved by DMA |
| stat_rd | input | 1 | Status read strobe; clears on the following edge |
| ev_en | input | 9 | Per-event interrupt enables, same bit order as `stat_q` |
| stat_q | output | 9 | Sticky event status |
| miss_cnt | output | 10 | Missed-frame count |
| irq | output | 1 | Level interrupt |

## Verification
The delicate collision is a status read in the same cycle that a new event arrives. The clear must drop every bit that was read, but it must not lose the event that lands on the clearing edge. The bench drives `stat_rd` and `dma_done` on one edge, and in another test `stat_rd` together with a byte-count crossing. It then expects `stat_q` to hold only the fresh bit. A second collision is the missed-frame strobe that wraps the counter. That strobe must set both the miss bit and the overflow bit on the same edge, and the bench checks both bits and the zero count together.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
    localparam int NEV       = 9;
    localparam int EV_GOOD   = 0;
    localparam int EV_CRC    = 1;
    localparam int EV_RUNT   = 2;
    localparam int EV_LONG   = 3;
    localparam int EV_DA     = 4;
    localparam int EV_EARLY  = 5;
    localparam int EV_MISS   = 6;
    localparam int EV_OVF    = 7;
    localparam int EV_DMA    = 8;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_WAIT_DA,
        TRK_WAIT_EARLY,
        TRK_DONE
    } trk_state_e;
endpackage

// File: rtl/rxirq_frame_trk.sv
module rxirq_frame_trk
    import rxirq_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int DA_BYTES    = 6,
    parameter int EARLY_BYTES = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_active,
    input  logic [CNT_W-1:0] byte_cnt,
    output logic             da_ev,
    output logic             early_ev
);
    localparam logic [CNT_W-1:0] DA_LIM    = CNT_W'(DA_BYTES);
    localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(EARLY_BYTES);

    trk_state_e state_q, state_d;
    logic       da_hit, early_hit;

    assign da_hit    = byte_cnt >= DA_LIM;
    assign early_hit = byte_cnt >= EARLY_LIM;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE, TRK_WAIT_DA: begin
                if (early_hit)   state_d = TRK_DONE;
                else if (da_hit) state_d = TRK_WAIT_EARLY;
                else             state_d = TRK_WAIT_DA;
            end
            TRK_WAIT_EARLY: if (early_hit) state_d = TRK_DONE;
            TRK_DONE:       state_d = TRK_DONE;
            default:        state_d = TRK_IDLE;
        endcase
        if (!frm_active) state_d = TRK_IDLE;
    end

    always_comb begin
        da_ev    = 1'b0;
        early_ev = 1'b0;
        unique case (state_q)
            TRK_IDLE, TRK_WAIT_DA: begin
                da_ev    = frm_active && da_hit;
                early_ev = frm_active && early_hit;
            end
            TRK_WAIT_EARLY: early_ev = frm_active && early_hit;
            TRK_DONE:       ;
            default:        ;
        endcase
    end
endmodule

// File: rtl/rxirq_frame_qual.sv
module rxirq_frame_qual (
    input  logic       frm_done,
    input  logic       da_pass,
    input  logic       crc_ok,
    input  logic       runt,
    input  logic       too_long,
    output logic [3:0] qual_ev
);
    logic take;
    assign take = frm_done && da_pass;

    always_comb begin
        qual_ev[0] = take && crc_ok && !runt && !too_long;
        qual_ev[1] = take && !crc_ok;
        qual_ev[2] = take && runt;
        qual_ev[3] = take && too_long;
    end
endmodule

// File: rtl/rxirq_miss_cnt.sv
module rxirq_miss_cnt #(
    parameter int MISS_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_stb,
    output logic [MISS_W-1:0] cnt_q,
    output logic              wrap_ev
);
    localparam logic [MISS_W-1:0] TOP = {MISS_W{1'b1}};

    assign wrap_ev = miss_stb && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (miss_stb) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rx_event_irq.sv
module rx_event_irq
    import rxirq_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int DA_BYTES    = 6,
    parameter int EARLY_BYTES = 128,
    parameter int MISS_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_active,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              frm_done,
    input  logic              frm_da_pass,
    input  logic              frm_crc_ok,
    input  logic              frm_runt,
    input  logic              frm_long,
    input  logic              miss_stb,
    input  logic              dma_done,
    input  logic              stat_rd,
    input  logic [NEV-1:0]    ev_en,
    output logic [NEV-1:0]    stat_q,
    output logic [MISS_W-1:0] miss_cnt,
    output logic              irq
);
    logic [3:0]     qual_ev;
    logic           da_ev, early_ev, wrap_ev;
    logic [NEV-1:0] new_ev;

    rxirq_frame_qual u_qual (
        .frm_done (frm_done),
        .da_pass  (frm_da_pass),
        .crc_ok   (frm_crc_ok),
        .runt     (frm_runt),
        .too_long (frm_long),
        .qual_ev  (qual_ev)
    );

    rxirq_frame_trk #(
        .CNT_W       (CNT_W),
        .DA_BYTES    (DA_BYTES),
        .EARLY_BYTES (EARLY_BYTES)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_active (frm_active),
        .byte_cnt   (byte_cnt),
        .da_ev      (da_ev),
        .early_ev   (early_ev)
    );

    rxirq_miss_cnt #(.MISS_W(MISS_W)) u_miss (
        .clk      (clk),
        .rst_n    (rst_n),
        .miss_stb (miss_stb),
        .cnt_q    (miss_cnt),
        .wrap_ev  (wrap_ev)
    );

    always_comb begin
        new_ev               = '0;
        new_ev[EV_LONG:EV_GOOD] = qual_ev;
        new_ev[EV_DA]        = da_ev;
        new_ev[EV_EARLY]     = early_ev;
        new_ev[EV_MISS]      = miss_stb;
        new_ev[EV_OVF]       = wrap_ev;
        new_ev[EV_DMA]       = dma_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_rd ? '0 : stat_q) | new_ev;
    end

    assign irq = |(stat_q & ev_en);
endmodule

// File: rtl/rxirq_chk.sv
module rxirq_chk
    import rxirq_pkg::*;
#(
    parameter int MISS_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_done,
    input logic              frm_da_pass,
    input logic              frm_crc_ok,
    input logic              frm_runt,
    input logic              frm_long,
    input logic              miss_stb,
    input logic              dma_done,
    input logic              stat_rd,
    input logic [NEV-1:0]    stat_q,
    input logic [MISS_W-1:0] miss_cnt,
    input logic              irq
);
    localparam logic [MISS_W-1:0] TOP = {MISS_W{1'b1}};

    AST_GOOD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && frm_da_pass && frm_crc_ok && !frm_runt && !frm_long |=> stat_q[EV_GOOD]); // R1
    AST_CRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && frm_da_pass && !frm_crc_ok |=> stat_q[EV_CRC]); // R2
    AST_NO_FILTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !frm_da_pass && !stat_rd |=> stat_q[3:0] == $past(stat_q[3:0])); // R3
    AST_MISS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stb || dma_done |=> stat_q[EV_MISS] == $past(miss_stb) || stat_q[EV_DMA] == $past(dma_done)); // R6
    AST_MISS_INC: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stb |=> miss_cnt == $past(miss_cnt) + 1'b1); // R7
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stb && miss_cnt == TOP |=> miss_cnt == '0 && stat_q[EV_OVF]); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q == '0 |-> !irq); // R10
endmodule

bind rx_event_irq rxirq_chk #(.MISS_W(MISS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_done    (frm_done),
    .frm_da_pass (frm_da_pass),
    .frm_crc_ok  (frm_crc_ok),
    .frm_runt    (frm_runt),
    .frm_long    (frm_long),
    .miss_stb    (miss_stb),
    .dma_done    (dma_done),
    .stat_rd     (stat_rd),
    .stat_q      (stat_q),
    .miss_cnt    (miss_cnt),
    .irq         (irq)
);

// File: tb/tb_rx_event_irq.sv
module tb_rx_event_irq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frm_active, frm_done, frm_da_pass, frm_crc_ok, frm_runt, frm_long;
    logic [10:0] byte_cnt;
    logic        miss_stb, dma_done, stat_rd;
    logic [8:0]  ev_en;
    logic [8:0]  stat_q;
    logic [9:0]  miss_cnt;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_miss = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rx_event_irq dut (
        .clk(clk), .rst_n(rst_n), .frm_active(frm_active), .byte_cnt(byte_cnt),
        .frm_done(frm_done), .frm_da_pass(frm_da_pass), .frm_crc_ok(frm_crc_ok),
        .frm_runt(frm_runt), .frm_long(frm_long), .miss_stb(miss_stb),
        .dma_done(dma_done), .stat_rd(stat_rd), .ev_en(ev_en),
        .stat_q(stat_q), .miss_cnt(miss_cnt), .irq(irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic end_frame(input bit pass, input bit crc, input bit runt, input bit lng);
        frm_done = 1'b1; frm_da_pass = pass; frm_crc_ok = crc; frm_runt = runt; frm_long = lng;
        tick();
        frm_done = 1'b0; frm_da_pass = 1'b0; frm_crc_ok = 1'b0; frm_runt = 1'b0; frm_long = 1'b0;
    endtask

    task automatic pulse_miss();
        miss_stb = 1'b1; tick(); miss_stb = 1'b0;
        exp_miss = (exp_miss + 1) % 1024;
    endtask

    task automatic t_reset();
        chk(stat_q == 9'h0, "R11 stat", stat_q, 0);
        chk(miss_cnt == 10'h0, "R11 miss_cnt", miss_cnt, 0);
        chk(irq == 1'b0, "R11 irq", irq, 0);
    endtask

    task automatic t_quality();
        end_frame(1, 1, 0, 0);
        chk(stat_q == 9'h001, "R1 good frame", stat_q, 9'h001);
        clr();
        end_frame(1, 0, 0, 0);
        chk(stat_q == 9'h002, "R2 crc", stat_q, 9'h002);
        clr();
        end_frame(1, 1, 1, 0);
        chk(stat_q == 9'h004, "R2 runt", stat_q, 9'h004);
        clr();
        end_frame(1, 1, 0, 1);
        chk(stat_q == 9'h008, "R2 long", stat_q, 9'h008);
        clr();
        end_frame(1, 0, 1, 0);
        chk(stat_q == 9'h006, "R2 crc+runt", stat_q, 9'h006);
        clr();
        end_frame(0, 1, 0, 0);
        end_frame(0, 0, 1, 1);
        chk(stat_q == 9'h000, "R3 filtered", stat_q, 0);
    endtask

    task automatic t_early();
        frm_active = 1'b1;
        for (int i = 1; i <= 5; i++) begin byte_cnt = 11'(i); tick(); end
        chk(stat_q[4] == 1'b0, "R4 before 6", stat_q, 0);
        byte_cnt = 11'd6; tick();
        chk(stat_q == 9'h010, "R4 at 6", stat_q, 9'h010);
        byte_cnt = 11'd7; stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        for (int i = 8; i <= 127; i++) begin byte_cnt = 11'(i); tick(); end
        chk(stat_q == 9'h000, "R4 once per frame", stat_q, 0);
        byte_cnt = 11'd128; tick();
        chk(stat_q == 9'h020, "R5 at 128", stat_q, 9'h020);
        clr();
        for (int i = 129; i <= 160; i++) begin byte_cnt = 11'(i); tick(); end
        chk(stat_q == 9'h000, "R5 once per frame", stat_q, 0);
        frm_active = 1'b0; byte_cnt = 11'd0; tick();
        frm_active = 1'b1;
        for (int i = 1; i <= 127; i++) begin byte_cnt = 11'(i); tick(); end
        clr();
        byte_cnt = 11'd128; stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk(stat_q == 9'h020, "R9 R5 read same cycle as crossing", stat_q, 9'h020);
        frm_active = 1'b0; byte_cnt = 11'd0; tick();
        clr();
    endtask

    task automatic t_miss_dma();
        pulse_miss();
        chk(stat_q == 9'h040, "R6 miss bit", stat_q, 9'h040);
        chk(miss_cnt == 10'(exp_miss), "R7 count", miss_cnt, exp_miss);
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        chk(stat_q == 9'h140, "R9 R6 dma sticky", stat_q, 9'h140);
        dma_done = 1'b1; stat_rd = 1'b1; tick(); dma_done = 1'b0; stat_rd = 1'b0;
        chk(stat_q == 9'h100, "R9 read with new event", stat_q, 9'h100);
        tick();
        chk(stat_q == 9'h100, "R9 holds", stat_q, 9'h100);
        clr();
        chk(stat_q == 9'h000, "R9 cleared", stat_q, 0);
    endtask

    task automatic t_overflow();
        while (exp_miss != 1023) pulse_miss();
        chk(miss_cnt == 10'd1023, "R7 at top", miss_cnt, 1023);
        chk(stat_q[7] == 1'b0, "R8 no early ovf", stat_q, 0);
        clr();
        pulse_miss();
        chk(miss_cnt == 10'd0, "R8 wrap", miss_cnt, 0);
        chk(stat_q == 9'h0C0, "R8 ovf+miss", stat_q, 9'h0C0);
        clr();
    endtask

    task automatic t_irq();
        ev_en = 9'h000;
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        chk(irq == 1'b0 && stat_q == 9'h100, "R10 disabled latched", {irq, stat_q}, 9'h100);
        ev_en = 9'h0FF;
        #1 chk(irq == 1'b0, "R10 other enables", irq, 0);
        ev_en = 9'h100;
        #1 chk(irq == 1'b1, "R10 enabled", irq, 1);
        clr();
        chk(irq == 1'b0, "R10 after read", irq, 0);
        ev_en = 9'h1FF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frm_active = 1'b0; byte_cnt = '0; frm_done = 1'b0;
        frm_da_pass = 1'b0; frm_crc_ok = 1'b0; frm_runt = 1'b0; frm_long = 1'b0;
        miss_stb = 1'b0; dma_done = 1'b0; stat_rd = 1'b0; ev_en = 9'h1FF;
        repeat (3) tick();
        rst_n = 1'b1; tick();
        t_reset();
        t_quality();
        clr();
        t_early();
        t_miss_dma();
        t_overflow();
        t_irq();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule